// File: doc/BRIEF.md
# Strobed Byte Handshake Controller

This block moves single bytes between a host and a peer device over four handshake wires. For outbound bytes, the host loads a pending value. The peer then strobes its "ready to take" line. On that strobe the pending value goes onto the output port and a "data valid" line is raised toward the peer. For inbound bytes, the peer places a byte on the input port and strobes its "byte offered" line. The block latches the byte into a holding register. It returns an acknowledge pulse only after the host has actually read that byte.

Both peer strobes pass through a synchronizer and an edge detector. A single input selects whether rising or falling transitions count as strobes. A host read always gets a response one cycle later. The response either carries the held byte with a ready flag, or reports not-ready with zero data when no byte is waiting. A sticky overrun flag records any strobe that arrives while a byte is still unread.

Top module: `hs_byte_xfer`

## Requirements
- R1: Once reset is released, `take_vld_o`, `give_ack_o`, `overrun_o`, `rd_valid_o`, `rd_ready_o` all read 0, as does `port_out_o`, which reads 0x00.
- R2: With `edge_neg_i`=0 only a 0-to-1 transition of a strobe line counts; with `edge_neg_i`=1 only a 1-to-0 transition counts; the opposite transition changes nothing.
- R3: A strobe line held at its active level counts as exactly one strobe, however long it is held.
- R4: A counted transition of `take_req_i` copies the pending byte to `port_out_o` and raises `take_vld_o`; both become visible at the third rising clock edge after the line changes (two synchronizer stages plus one edge register).
- R5: `take_vld_o` stays 0 until the first counted `take_req_i` strobe. A `host_load_i` pulse stores `host_wdata_i` as the new pending byte and forces `take_vld_o` to 0 on the next edge. If a load and a strobe fall in the same cycle, `port_out_o` receives the previous pending byte and `take_vld_o` ends at 0.
- R6: A counted `give_stb_i` strobe with the holding register empty latches `port_in_i`; `give_ack_o` does not rise because of the strobe.
- R7: A `host_rd_i` pulse with a byte held gives, on the next cycle, `rd_valid_o`=1, `rd_ready_o`=1 and `host_rdata_o` equal to the held byte.
- R8: A `host_rd_i` pulse with no byte held gives, on the next cycle, `rd_valid_o`=1, `rd_ready_o`=0 and `host_rdata_o`=0x00.
- R9: After a byte has been read, further reads report not-ready until another `give_stb_i` strobe is counted.
- R10: An accepted read raises `give_ack_o` from the next cycle for exactly `ack_len_i` cycles (a value of 0 acts as 1); the receive side then returns to empty.
- R11: A `give_stb_i` strobe that arrives while a byte is still unread sets `overrun_o` and leaves the held byte unchanged. `overrun_o` then stays at 1 until reset.
- R12: A `give_stb_i` strobe counted while `give_ack_o` is high ends the acknowledge pulse and latches the new byte for reading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| edge_neg_i | input | 1 | 0: rising transitions are strobes, 1: falling transitions are strobes |
| ack_len_i | input | ACK_CNT_W | Acknowledge pulse length in cycles (0 treated as 1) |
| take_req_i | input | 1 | Peer is ready to take a byte (strobe line, asynchronous) |
| take_vld_o | output | 1 | Outbound byte on the port is valid for the peer |
| give_stb_i | input | 1 | Peer offers a byte on the input port (strobe line, asynchronous) |
| give_ack_o | output | 1 | Offered byte has been consumed by the host |
| port_in_i | input | DATA_W | Inbound data from the peer |
| port_out_o | output | DATA_W | Outbound data to the peer |
| host_load_i | input | 1 | Load a new pending outbound byte |
| host_wdata_i | input | DATA_W | Pending outbound byte |
| host_rd_i | input | 1 | Host read request |
| rd_valid_o | output | 1 | Read response present |
| rd_ready_o | output | 1 | Read response carries data (0: not ready) |
| host_rdata_o | output | DATA_W | Read data (0 when not ready) |
| overrun_o | output | 1 | Sticky: a strobe arrived while a byte was unread |

## Verification
The bench targets the corners where a handshake quietly goes wrong. It holds a strobe high for many cycles; a level-triggered design would move a fresh byte each cycle. It lands a host load on the very cycle a strobe is consumed; a wrong priority would leave the data-valid line high over stale data. It reads with nothing held and reads twice after one capture; a design that returns stale data there would report ready with an old byte. It sends a second strobe over an unread byte and another during the acknowledge pulse, which catches a design that overwrites the held byte or keeps acknowledging. It counts the acknowledge pulse width cycle by cycle and repeats the strobe checks with falling-edge selection.

// File: rtl/hs_pkg.sv
// Package: shared types for the strobed byte handshake controller.
// Assumes: nothing beyond IEEE 1800-2017.
package hs_pkg;

    // Receive-side holding register state.
    typedef enum logic [1:0] {
        RX_EMPTY  = 2'd0,
        RX_HELD   = 2'd1,
        RX_ACKING = 2'd2
    } rx_state_e;

endpackage

// File: rtl/hs_edge_sync.sv
// Module: hs_edge_sync
// Synchronizes one asynchronous strobe line and emits a single-cycle pulse
// for each transition in the selected direction.
// Assumes: STAGES >= 1; the line idles at 0 for rising mode and at 1 for
// falling mode, so the chain's reset value of 0 never fakes a falling edge.
module hs_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_neg_i,
    input  logic line_i,
    output logic pulse_o
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;
    logic              synced;

    generate
        if (STAGES == 1) begin : g_single
            // Single-flop capture of the asynchronous line.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= line_i;
            end
        end else begin : g_multi
            // Shift the line through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], line_i};
            end
        end
    endgenerate

    assign synced = chain_q[STAGES-1];

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= synced;
    end

    // Select rising or falling transition as the strobe.
    always_comb begin
        if (edge_neg_i) pulse_o = prev_q & ~synced;
        else            pulse_o = synced & ~prev_q;
    end

endmodule

// File: rtl/hs_tx_side.sv
// Module: hs_tx_side
// Holds the pending outbound byte, moves it to the port on each counted
// peer strobe and drives the data-valid line.
// Assumes: take_stb_i is a single-cycle synchronous pulse.
module hs_tx_side #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_stb_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] port_out_o,
    output logic              vld_o
);

    logic [DATA_W-1:0] pend_q;

    // Store the host's pending byte.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_q <= '0;
        else if (load_i) pend_q <= wdata_i;
    end

    // Present the pending byte on the port when the peer strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)          port_out_o <= '0;
        else if (take_stb_i) port_out_o <= pend_q;
    end

    // Data-valid: cleared by a load, set by a strobe, load has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)          vld_o <= 1'b0;
        else if (load_i)     vld_o <= 1'b0;
        else if (take_stb_i) vld_o <= 1'b1;
    end

endmodule

// File: rtl/hs_rx_side.sv
// Module: hs_rx_side
// Latches an offered byte, answers host reads with data or not-ready,
// and returns a timed acknowledge only after the byte has been read.
// Assumes: give_stb_i is a single-cycle synchronous pulse; port_in_i is
// stable by the time the strobe has crossed the synchronizer.
module hs_rx_side
    import hs_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int ACK_CNT_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 give_stb_i,
    input  logic [DATA_W-1:0]    port_in_i,
    input  logic                 rd_i,
    input  logic [ACK_CNT_W-1:0] ack_len_i,
    output logic                 rd_valid_o,
    output logic                 rd_ready_o,
    output logic [DATA_W-1:0]    rdata_o,
    output logic                 ack_o,
    output logic                 overrun_o
);

    localparam logic [ACK_CNT_W-1:0] ONE = {{(ACK_CNT_W-1){1'b0}}, 1'b1};

    rx_state_e            state_q;
    logic [DATA_W-1:0]    hold_q;
    logic [ACK_CNT_W-1:0] cnt_q;
    logic [ACK_CNT_W-1:0] len_eff;

    // Treat a zero pulse length as a single cycle.
    always_comb begin
        len_eff = (ack_len_i == '0) ? ONE : ack_len_i;
    end

    // Host read response, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_o <= 1'b0;
            rd_ready_o <= 1'b0;
            rdata_o    <= '0;
        end else begin
            rd_valid_o <= rd_i;
            if (rd_i && state_q == RX_HELD) begin
                rd_ready_o <= 1'b1;
                rdata_o    <= hold_q;
            end else begin
                rd_ready_o <= 1'b0;
                rdata_o    <= '0;
            end
        end
    end

    // Sticky overrun when a strobe meets an unread byte.
    always_ff @(posedge clk) begin
        if (!rst_n) overrun_o <= 1'b0;
        else if (give_stb_i && state_q == RX_HELD) overrun_o <= 1'b1;
    end

    // Receive state machine: capture, wait for read, acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_EMPTY;
            hold_q  <= '0;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                RX_EMPTY: begin
                    if (give_stb_i) begin
                        hold_q  <= port_in_i;
                        state_q <= RX_HELD;
                    end
                end
                RX_HELD: begin
                    if (rd_i) begin
                        cnt_q   <= len_eff;
                        state_q <= RX_ACKING;
                    end
                end
                RX_ACKING: begin
                    if (give_stb_i) begin
                        hold_q  <= port_in_i;
                        state_q <= RX_HELD;
                    end else if (cnt_q <= ONE) begin
                        state_q <= RX_EMPTY;
                    end else begin
                        cnt_q <= cnt_q - ONE;
                    end
                end
                default: state_q <= RX_EMPTY;
            endcase
        end
    end

    assign ack_o = (state_q == RX_ACKING);

endmodule

// File: rtl/hs_byte_xfer.sv
// Module: hs_byte_xfer (top)
// Four-wire strobed byte transfer controller: two synchronized strobe
// inputs, a data-valid and an acknowledge output, and a host side with a
// pending-byte load and a read with data/not-ready response.
// Assumes: strobe lines are asynchronous to clk; data ports are stable
// around their strobes.
module hs_byte_xfer #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int ACK_CNT_W   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 edge_neg_i,
    input  logic [ACK_CNT_W-1:0] ack_len_i,
    input  logic                 take_req_i,
    output logic                 take_vld_o,
    input  logic                 give_stb_i,
    output logic                 give_ack_o,
    input  logic [DATA_W-1:0]    port_in_i,
    output logic [DATA_W-1:0]    port_out_o,
    input  logic                 host_load_i,
    input  logic [DATA_W-1:0]    host_wdata_i,
    input  logic                 host_rd_i,
    output logic                 rd_valid_o,
    output logic                 rd_ready_o,
    output logic [DATA_W-1:0]    host_rdata_o,
    output logic                 overrun_o
);

    logic take_pulse;
    logic give_pulse;

    hs_edge_sync #(.STAGES(SYNC_STAGES)) u_take_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_neg_i (edge_neg_i),
        .line_i     (take_req_i),
        .pulse_o    (take_pulse)
    );

    hs_edge_sync #(.STAGES(SYNC_STAGES)) u_give_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_neg_i (edge_neg_i),
        .line_i     (give_stb_i),
        .pulse_o    (give_pulse)
    );

    hs_tx_side #(.DATA_W(DATA_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_stb_i (take_pulse),
        .load_i     (host_load_i),
        .wdata_i    (host_wdata_i),
        .port_out_o (port_out_o),
        .vld_o      (take_vld_o)
    );

    hs_rx_side #(.DATA_W(DATA_W), .ACK_CNT_W(ACK_CNT_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .give_stb_i (give_pulse),
        .port_in_i  (port_in_i),
        .rd_i       (host_rd_i),
        .ack_len_i  (ack_len_i),
        .rd_valid_o (rd_valid_o),
        .rd_ready_o (rd_ready_o),
        .rdata_o    (host_rdata_o),
        .ack_o      (give_ack_o),
        .overrun_o  (overrun_o)
    );

endmodule

// File: rtl/hs_byte_xfer_chk.sv
// Module: hs_byte_xfer_chk
// Protocol checker bound to hs_byte_xfer; observes ports only.
// Assumes: synchronous active-low reset on rst_n.
module hs_byte_xfer_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              take_vld_o,
    input logic              give_ack_o,
    input logic              host_load_i,
    input logic              host_rd_i,
    input logic              rd_valid_o,
    input logic              rd_ready_o,
    input logic [DATA_W-1:0] host_rdata_o,
    input logic              overrun_o
);

    // R5: a load drops data-valid on the next edge.
    p_load_drops_vld_r5: assert property (@(posedge clk) disable iff (!rst_n)
        host_load_i |=> !take_vld_o);

    // R5: data-valid never rises in the cycle after a load.
    p_vld_rise_no_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_vld_o) |-> !$past(host_load_i));

    // R7: a response only follows a request.
    p_resp_after_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> $past(host_rd_i));

    // R7: ready is only flagged on a response.
    p_ready_in_resp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready_o |-> rd_valid_o);

    // R8: not-ready responses carry zero data.
    p_notready_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && !rd_ready_o) |-> (host_rdata_o == '0));

    // R10: acknowledge rises only right after a read.
    p_ack_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(give_ack_o) |-> $past(host_rd_i));

    // R11: overrun is sticky.
    p_overrun_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o);

endmodule

bind hs_byte_xfer hs_byte_xfer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .take_vld_o   (take_vld_o),
    .give_ack_o   (give_ack_o),
    .host_load_i  (host_load_i),
    .host_rd_i    (host_rd_i),
    .rd_valid_o   (rd_valid_o),
    .rd_ready_o   (rd_ready_o),
    .host_rdata_o (host_rdata_o),
    .overrun_o    (overrun_o)
);

// File: tb/hs_byte_xfer_bench.sv
// Bench for hs_byte_xfer: scoreboard for host read responses plus direct
// port checks for the handshake lines.
module hs_byte_xfer_bench;

    localparam int DW = 8;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          edge_neg = 1'b0;
    logic [AW-1:0] ack_len = 4'd3;
    logic          take_req = 1'b0;
    logic          take_vld;
    logic          give_stb = 1'b0;
    logic          give_ack;
    logic [DW-1:0] port_in = '0;
    logic [DW-1:0] port_out;
    logic          host_load = 1'b0;
    logic [DW-1:0] host_wdata = '0;
    logic          host_rd = 1'b0;
    logic          rd_valid;
    logic          rd_ready;
    logic [DW-1:0] host_rdata;
    logic          overrun;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    typedef struct packed {
        logic          rdy;
        logic [DW-1:0] dat;
        logic [7:0]    req;
    } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    hs_byte_xfer #(.DATA_W(DW), .SYNC_STAGES(2), .ACK_CNT_W(AW)) u_hs_byte_xfer (
        .clk          (clk),
        .rst_n        (rst_n),
        .edge_neg_i   (edge_neg),
        .ack_len_i    (ack_len),
        .take_req_i   (take_req),
        .take_vld_o   (take_vld),
        .give_stb_i   (give_stb),
        .give_ack_o   (give_ack),
        .port_in_i    (port_in),
        .port_out_o   (port_out),
        .host_load_i  (host_load),
        .host_wdata_i (host_wdata),
        .host_rd_i    (host_rd),
        .rd_valid_o   (rd_valid),
        .rd_ready_o   (rd_ready),
        .host_rdata_o (host_rdata),
        .overrun_o    (overrun)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Monitor: pop the expected response whenever one appears.
    always @(negedge clk) begin
        if (rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(rd_ready == e.rdy && host_rdata == e.dat,
                      (e.req == 8) ? "R8" : (e.req == 9) ? "R9" :
                      (e.req == 11) ? "R11" : (e.req == 12) ? "R12" :
                      (e.req == 2) ? "R2" : "R7",
                      {rd_ready, host_rdata}, {e.rdy, e.dat});
            end
        end
    end

    // Driver: issue a read and queue its expected response.
    task automatic host_read(input logic rdy, input logic [DW-1:0] dat, input int req);
        @(negedge clk);
        host_rd = 1'b1;
        exp_q.push_back({rdy, dat, 8'(req)});
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic load_byte(input logic [DW-1:0] v);
        @(negedge clk);
        host_load  = 1'b1;
        host_wdata = v;
        @(negedge clk);
        host_load  = 1'b0;
    endtask

    // Change a line and return at the negedge where its effect is visible.
    task automatic set_take(input logic v);
        @(negedge clk);
        take_req = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic set_give(input logic v);
        @(negedge clk);
        give_stb = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual 0 expected 1");
        finish_run();
    end

    initial begin
        int cnt;
        do_reset();
        // R1 reset state
        check(take_vld == 0 && give_ack == 0 && overrun == 0, "R1", {take_vld, give_ack, overrun}, 0);
        check(rd_valid == 0 && rd_ready == 0, "R1 rd", {rd_valid, rd_ready}, 0);
        check(port_out == 8'h00, "R1 port", port_out, 0);
        // R8 read with nothing held
        host_read(1'b0, 8'h00, 8);

        // R4/R5 outbound path
        load_byte(8'h55);
        check(take_vld == 0, "R5 vld before strobe", take_vld, 0);
        @(negedge clk);
        take_req = 1'b1;
        repeat (2) @(negedge clk);
        check(take_vld == 0, "R4 latency early", take_vld, 0);
        @(negedge clk);
        check(take_vld == 1 && port_out == 8'h55, "R4", {take_vld, port_out}, 9'h155);

        // R3: held level gives one strobe only
        load_byte(8'hA3);
        check(take_vld == 0, "R5 load clears vld", take_vld, 0);
        repeat (8) @(negedge clk);
        check(take_vld == 0 && port_out == 8'h55, "R3", {take_vld, port_out}, 9'h055);
        // R2: falling edge ignored in rising mode
        set_take(1'b0);
        check(take_vld == 0 && port_out == 8'h55, "R2 fall ignored", {take_vld, port_out}, 9'h055);
        set_take(1'b1);
        check(take_vld == 1 && port_out == 8'hA3, "R4 second", {take_vld, port_out}, 9'h1A3);
        set_take(1'b0);

        // R5: load in the strobe's consumption cycle
        load_byte(8'h11);
        @(negedge clk);
        take_req = 1'b1;
        @(negedge clk);
        @(negedge clk);
        host_load  = 1'b1;
        host_wdata = 8'h77;
        @(negedge clk);
        host_load  = 1'b0;
        check(take_vld == 0 && port_out == 8'h11, "R5 collision", {take_vld, port_out}, 9'h011);
        set_take(1'b0);
        set_take(1'b1);
        check(take_vld == 1 && port_out == 8'h77, "R5 after collision", {take_vld, port_out}, 9'h177);

        // R6/R7/R10/R9 inbound path
        ack_len = 4'd3;
        port_in = 8'h5A;
        set_give(1'b1);
        check(give_ack == 0, "R6 no ack on strobe", give_ack, 0);
        repeat (5) @(negedge clk);
        check(give_ack == 0, "R6 no ack while held", give_ack, 0);
        host_read(1'b1, 8'h5A, 7);
        cnt = 0;
        while (give_ack && cnt < 40) begin
            cnt++;
            @(negedge clk);
        end
        check(cnt == 3, "R10 ack width", cnt, 3);
        host_read(1'b0, 8'h00, 9);
        host_read(1'b0, 8'h00, 9);
        set_give(1'b0);

        // R10: zero length acts as one
        ack_len = 4'd0;
        port_in = 8'h3E;
        set_give(1'b1);
        host_read(1'b1, 8'h3E, 7);
        cnt = 0;
        while (give_ack && cnt < 40) begin
            cnt++;
            @(negedge clk);
        end
        check(cnt == 1, "R10 zero length", cnt, 1);
        set_give(1'b0);

        // R11 overrun
        check(overrun == 0, "R11 clear before", overrun, 0);
        port_in = 8'hC4;
        set_give(1'b1);
        set_give(1'b0);
        port_in = 8'h99;
        set_give(1'b1);
        check(overrun == 1, "R11 set", overrun, 1);
        host_read(1'b1, 8'hC4, 11);
        repeat (20) @(negedge clk);
        check(overrun == 1, "R11 sticky", overrun, 1);
        set_give(1'b0);

        // R12 strobe during acknowledge
        do_reset();
        ack_len = 4'd15;
        port_in = 8'h21;
        set_give(1'b1);
        set_give(1'b0);
        host_read(1'b1, 8'h21, 7);
        check(give_ack == 1, "R10 ack starts", give_ack, 1);
        port_in = 8'h42;
        set_give(1'b1);
        check(give_ack == 0 && overrun == 0, "R12 ack ended", {give_ack, overrun}, 0);
        host_read(1'b1, 8'h42, 12);
        set_give(1'b0);

        // R2 falling-edge mode (lines idle high)
        edge_neg = 1'b1;
        take_req = 1'b1;
        give_stb = 1'b1;
        do_reset();
        check(take_vld == 0, "R2 rise ignored after reset", take_vld, 0);
        load_byte(8'h6D);
        set_take(1'b0);
        check(take_vld == 1 && port_out == 8'h6D, "R2 fall counted", {take_vld, port_out}, 9'h16D);
        load_byte(8'h12);
        set_take(1'b1);
        check(take_vld == 0 && port_out == 8'h6D, "R2 rise ignored", {take_vld, port_out}, 9'h06D);
        port_in = 8'hE7;
        set_give(1'b0);
        host_read(1'b1, 8'hE7, 2);
        set_give(1'b1);
        host_read(1'b0, 8'h00, 2);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R7 responses drained", exp_q.size(), 0);
        finish_run();
    end

endmodule